// File: doc/BRIEF.md
# Power-On Memory Shadow Copier

After reset, this sequencer copies the host's whole address space into on-chip RAM before the processor core runs. It walks the addresses one at a time. For each address that is not an I/O location, it asks a slow external bus bridge for the byte stored there. When the byte comes back, the sequencer writes it into the internal RAM at the same address.

The I/O holes are taken from a switch-selected memory map. There are sixteen maps. The bridge uses the same map selection, so the copier never touches a peripheral register. While the copy runs, the core is kept in reset. Once the image is complete, the core is released and fetches its reset vector from the copied memory.

With the default parameters the block covers a 64 KB space. Every size is a parameter, so a narrower address space can be used for shorter runs.

Top module: `shadow_copier`

## Requirements
- R1: While `rst` is high and in the cycles after it, `busy` and `core_rst` are 1 and `br_req` and `ram_we` are 0. Once `rst` falls, the copy starts by itself, and the first bridge read targets address 0.
- R2: Every address that is not an I/O location is read from the bridge exactly once. It is written into the RAM exactly once, at the same address.
- R3: An address is an I/O location when the map value is nonzero and the top eight address bits equal the hex digit C followed by the four map bits. Map value 0 has no I/O hole. I/O addresses are never read from the bridge and never written into the RAM.
- R4: `map_sel` is sampled while `rst` is high. Changing it after reset has no effect on which addresses are skipped during the copy.
- R5: Bridge reads are issued in strictly ascending address order.
- R6: Only one read is outstanding at a time. `br_req` stays high, with `br_addr` unchanged, until the cycle in which `br_done` is seen. It is low in the following cycle.
- R7: In the cycle after `br_done` is seen, `ram_we` is 1, `ram_addr` is the address that was read, and `ram_wdata` is the `br_rdata` value of the `br_done` cycle.
- R8: `core_rst` equals `busy` at all times. Both stay 1 until the last address has been handled. Both fall in the cycle after the final RAM write strobe.
- R9: After the copy ends, `busy` and `core_rst` stay 0, and no further bridge read or RAM write occurs until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new copy when released |
| map_sel | input | MAP_W | Memory map selection switch, sampled during reset |
| br_req | output | 1 | Read request to the external bus bridge |
| br_addr | output | ADDR_W | Address of the requested read |
| br_rdata | input | DATA_W | Byte returned by the bridge, valid with `br_done` |
| br_done | input | 1 | Single-cycle completion pulse from the bridge |
| ram_we | output | 1 | Internal RAM write strobe |
| ram_addr | output | ADDR_W | Internal RAM write address |
| ram_wdata | output | DATA_W | Internal RAM write data |
| core_rst | output | 1 | Reset to the processor core, held until the copy completes |
| busy | output | 1 | High while the copy is in progress |

## Verification
The checks assume a well-behaved bridge. `br_done` pulses for a single cycle, only while `br_req` is high, and never in the cycle right after an earlier pulse. `br_rdata` is valid in the pulse cycle. `map_sel` is steady for the last cycle of reset.

The bench's bridge model follows these rules. It answers each request after a random wait of zero to three cycles and only reacts to a request it sees at the falling edge. This keeps the done pulse inside the request window. The bench changes `map_sel` only after reset has been released, and that change is the stimulus for the check that the map is latched.

// File: rtl/shadow_copier_pkg.sv
package shadow_copier_pkg;

  typedef enum logic [1:0] {
    ST_CHECK,
    ST_WAIT,
    ST_FLUSH,
    ST_DONE
  } copy_state_t;

  localparam int IO_TAG_HI_W = 4;
  localparam logic [IO_TAG_HI_W-1:0] IO_TAG_HI = 4'hC;

endpackage

// File: rtl/shadow_io_decode.sv
module shadow_io_decode
  import shadow_copier_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MAP_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MAP_W-1:0]  map,
  output logic              is_io
);

  localparam int TAG_W = IO_TAG_HI_W + MAP_W;

  logic [TAG_W-1:0] tag;

  assign tag = addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    is_io = (map != '0) && (tag == {IO_TAG_HI, map});
  end

endmodule

// File: rtl/shadow_addr_walker.sv
module shadow_addr_walker #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  assign last = &addr;

endmodule

// File: rtl/shadow_copier.sv
module shadow_copier
  import shadow_copier_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAP_W-1:0]  map_sel,
  output logic              br_req,
  output logic [ADDR_W-1:0] br_addr,
  input  logic [DATA_W-1:0] br_rdata,
  input  logic              br_done,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              core_rst,
  output logic              busy
);

  copy_state_t       state;
  logic [MAP_W-1:0]  map_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_last;
  logic              cur_io;
  logic              step;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= map_sel;
    end
  end

  shadow_io_decode #(
    .ADDR_W(ADDR_W),
    .MAP_W (MAP_W)
  ) u_decode (
    .addr (cur_addr),
    .map  (map_q),
    .is_io(cur_io)
  );

  always_comb begin
    step = ((state == ST_CHECK) && cur_io) ||
           ((state == ST_WAIT) && br_done);
  end

  shadow_addr_walker #(
    .ADDR_W(ADDR_W)
  ) u_walker (
    .clk (clk),
    .rst (rst),
    .step(step),
    .addr(cur_addr),
    .last(cur_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CHECK;
      br_req    <= 1'b0;
      br_addr   <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      busy      <= 1'b1;
      core_rst  <= 1'b1;
    end else begin
      ram_we <= 1'b0;
      case (state)
        ST_CHECK: begin
          if (cur_io) begin
            if (cur_last) state <= ST_FLUSH;
          end else begin
            br_req  <= 1'b1;
            br_addr <= cur_addr;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (br_done) begin
            br_req    <= 1'b0;
            ram_we    <= 1'b1;
            ram_addr  <= cur_addr;
            ram_wdata <= br_rdata;
            state     <= cur_last ? ST_FLUSH : ST_CHECK;
          end
        end
        ST_FLUSH: begin
          busy     <= 1'b0;
          core_rst <= 1'b0;
          state    <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/shadow_copier_chk.sv
module shadow_copier_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              br_req,
  input logic [ADDR_W-1:0] br_addr,
  input logic [DATA_W-1:0] br_rdata,
  input logic              br_done,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              core_rst,
  input logic              busy
);

  // R6: request held with a steady address until the bridge answers
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (br_req && !br_done) |=> (br_req && $stable(br_addr)));

  // R6: request withdrawn right after completion
  assert_req_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (br_req && br_done) |=> !br_req);

  // R7: RAM write follows completion with the returned byte and read address
  assert_write_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (br_req && br_done) |=>
      (ram_we && ram_wdata == $past(br_rdata) && ram_addr == $past(br_addr)));

  // R8: core reset tracks busy
  assert_core_hold_R8: assert property (@(posedge clk) disable iff (rst)
    core_rst == busy);

  // R9: once finished, stays finished
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  // R9: no traffic after completion
  assert_quiet_after_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!br_req && !ram_we));

endmodule

bind shadow_copier shadow_copier_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .br_req   (br_req),
  .br_addr  (br_addr),
  .br_rdata (br_rdata),
  .br_done  (br_done),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .ram_wdata(ram_wdata),
  .core_rst (core_rst),
  .busy     (busy)
);

// File: tb/shadow_copier_tb.sv
module shadow_copier_tb;

  localparam int AW    = 12;
  localparam int DW    = 8;
  localparam int MW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] map_sel = '0;
  logic          br_req;
  logic [AW-1:0] br_addr;
  logic [DW-1:0] br_rdata = '0;
  logic          br_done = 1'b0;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic          core_rst;
  logic          busy;

  always #2 clk = ~clk;

  shadow_copier #(.ADDR_W(AW), .DATA_W(DW), .MAP_W(MW)) u_dut (
    .clk(clk), .rst(rst), .map_sel(map_sel),
    .br_req(br_req), .br_addr(br_addr), .br_rdata(br_rdata), .br_done(br_done),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .core_rst(core_rst), .busy(busy)
  );

  int total = 0;
  int bad   = 0;
  int rd_cnt [DEPTH];
  int wr_cnt [DEPTH];
  int last_rd;
  int first_rd;
  int salt;
  int pend_wait;
  bit exp_we;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_data;
  bit prev_req, prev_done;
  logic [AW-1:0] prev_addr;

  function automatic logic [DW-1:0] host_byte(int a, int s);
    return DW'((a * 37) ^ (a >> 3) ^ s);
  endfunction

  function automatic bit hole(int a, int m);
    return (m != 0) && (((a >> (AW - 8)) & 8'hFF) == (8'hC0 | m));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bridge model and output monitor, all at the falling edge
  initial begin
    pend_wait = $urandom(32'd2024) % 4;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (exp_we)
          check(ram_we === 1'b1 && ram_addr == exp_addr && ram_wdata == exp_data,
                "R7", "write after done", int'(ram_addr), int'(exp_addr));
        if (prev_req && !prev_done)
          check(br_req === 1'b1 && br_addr == prev_addr, "R6", "request held",
                int'(br_addr), int'(prev_addr));
        if (prev_done)
          check(br_req === 1'b0, "R6", "request dropped", int'(br_req), 0);
        if (ram_we === 1'b1) wr_cnt[ram_addr]++;
      end
      exp_we  = 1'b0;
      br_done = 1'b0;
      if (!rst && br_req === 1'b1) begin
        if (pend_wait == 0) begin
          br_done  = 1'b1;
          br_rdata = host_byte(int'(br_addr), salt);
          rd_cnt[br_addr]++;
          if (first_rd < 0) first_rd = int'(br_addr);
          check(int'(br_addr) > last_rd, "R5", "ascending order",
                int'(br_addr), last_rd + 1);
          last_rd   = int'(br_addr);
          exp_we    = 1'b1;
          exp_addr  = br_addr;
          exp_data  = br_rdata;
          pend_wait = $urandom_range(0, 3);
        end else begin
          pend_wait--;
        end
      end
      prev_req  = !rst && (br_req === 1'b1);
      prev_done = br_done;
      prev_addr = br_addr;
    end
  end

  task automatic run_copy(int map_rst, int map_after, int s);
    int n;
    bit prev_we;
    salt     = s;
    last_rd  = -1;
    first_rd = -1;
    for (int a = 0; a < DEPTH; a++) begin
      rd_cnt[a] = 0;
      wr_cnt[a] = 0;
    end
    @(negedge clk);
    rst     = 1'b1;
    map_sel = MW'(map_rst);
    repeat (3) @(negedge clk);
    check(busy === 1'b1 && core_rst === 1'b1 && br_req === 1'b0 && ram_we === 1'b0,
          "R1", "reset state", {busy, core_rst, br_req, ram_we}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    map_sel = MW'(map_after);  // R4: must be ignored
    n = 0;
    prev_we = 1'b0;
    while (busy === 1'b1 && n < 60000) begin
      check(core_rst === busy, "R8", "core_rst tracks busy", int'(core_rst), int'(busy));
      prev_we = ram_we;
      @(negedge clk);
      n++;
    end
    if (n >= 60000) begin
      check(1'b0, "R8", "watchdog: copy never ended", n, 0);
      return;
    end
    check(prev_we == 1'b1, "R8", "release one cycle after final write", int'(prev_we), 1);
    check(core_rst === 1'b0, "R8", "core released", int'(core_rst), 0);
    check(first_rd == 0, "R1", "first read address", first_rd, 0);
    for (int a = 0; a < DEPTH; a++) begin
      int e;
      e = hole(a, map_rst) ? 0 : 1;
      check(rd_cnt[a] == e, e ? "R2" : "R3", "read count", rd_cnt[a], e);
      check(wr_cnt[a] == e, e ? "R2" : "R3", "write count", wr_cnt[a], e);
      if (map_after != map_rst && hole(a, map_after) && !hole(a, map_rst))
        check(rd_cnt[a] == 1, "R4", "late map change ignored", rd_cnt[a], 1);
    end
    repeat (20) begin
      @(negedge clk);
      check(br_req === 1'b0 && ram_we === 1'b0 && busy === 1'b0 && core_rst === 1'b0,
            "R9", "quiet after copy", {br_req, ram_we, busy, core_rst}, 0);
    end
  endtask

  initial begin
    run_copy(0, 0, 8'h5A);
    run_copy(5, 9, 8'h13);
    run_copy(15, 3, 8'hC7);
    run_copy(12, 0, 8'h81);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule